// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches a vector of already-filtered general-purpose input lines and turns activity on them into interrupt status. Each line has its own trigger choice: rising edge, falling edge, either edge, high level or low level. The choice is spread over three per-line bit registers: a sense-kind bit (edge or level), a polarity bit and an any-edge bit. A per-line enable bit gates whether detection happens at all. Input lines first pass through a two-flop synchronizer. Detected events land in a raw status register. Edge events stay latched until software writes a one to the matching bit of the acknowledge register. Level events follow the pin on every clock.

A mask register hides lines from the masked status view, where a mask bit of 1 hides its line. The single interrupt output is the OR of all masked status bits. Software reaches the block through a synchronous register port. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the byte address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the enable, mask, sense-kind, any-edge, polarity, raw status and masked status registers all read 0, and the interrupt output is low.
- R2: A line in edge mode (sense-kind 0, any-edge 0, polarity 0) latches its raw status bit on a 0-to-1 transition of its pin. A 1-to-0 transition does not set the bit, and the bit stays set after the pin returns low.
- R3: A line in edge mode with polarity 1 and any-edge 0 latches its raw status on a 1-to-0 transition and ignores a 0-to-1 transition.
- R4: A line in edge mode with any-edge 1 latches its raw status on both transitions, whatever its polarity bit holds.
- R5: A line in level mode (sense-kind 1) has a raw status bit that follows its active level on every clock. The line is active-high when polarity is 0 and active-low when polarity is 1.
- R6: Writing 1 to a bit of the acknowledge register (byte offset 0x30) clears that line's latched edge status on the write edge. Writing 0 leaves it unchanged. For a level-mode line whose level is still active, the write has no lasting effect.
- R7: A line whose enable bit is 0 does not set its raw status. Turning the enable bit back on with the pin unchanged does not create an event.
- R8: Masked status equals raw status with every line whose mask bit is 1 removed. The interrupt output is high exactly when masked status is nonzero.
- R9: A pin change that is applied after a clock edge is first visible in raw status after the third following clock edge, because of the two-flop synchronizer.
- R10: Register byte offsets are: enable 0x20, raw status 0x24, masked status 0x28, mask 0x2C, acknowledge 0x30, sense-kind 0x34, any-edge 0x38, polarity 0x3C. The enable, mask, sense-kind, any-edge and polarity registers read back what was written. The acknowledge register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pins_in | input | 32 | Filtered input lines, asynchronous to clk |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each trigger mode is driven with both a rising and a falling pin transition. This separates rising-only, falling-only and either-edge sensing, and it shows that the polarity bit loses its meaning once any-edge is set. Level lines are driven into and out of their active level, with an acknowledge written in between. This separates a following status bit from a latched one. A single step-by-step read after one pin change pins down the three-edge latency. Enable gating, mask hiding and the acknowledge write of zero are each checked by reading status at the register port right after the stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h20;
    localparam logic [OFF_W-1:0] OFF_RAW    = 8'h24;
    localparam logic [OFF_W-1:0] OFF_MASKED = 8'h28;
    localparam logic [OFF_W-1:0] OFF_MASK   = 8'h2C;
    localparam logic [OFF_W-1:0] OFF_ACK    = 8'h30;
    localparam logic [OFF_W-1:0] OFF_KIND   = 8'h34;
    localparam logic [OFF_W-1:0] OFF_ANY    = 8'h38;
    localparam logic [OFF_W-1:0] OFF_POL    = 8'h3C;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_async,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pins_async;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] en,
    input  logic [N-1:0] kind,
    input  logic [N-1:0] any_edge,
    input  logic [N-1:0] pol,
    output logic [N-1:0] edge_hit,
    output logic [N-1:0] lvl_act
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic went_up;
        logic went_down;
        logic hit;

        assign went_up   = cur[i] & ~prev[i];
        assign went_down = ~cur[i] & prev[i];
        assign hit       = any_edge[i] ? (went_up | went_down)
                                       : (pol[i] ? went_down : went_up);
        assign edge_hit[i] = en[i] & ~kind[i] & hit;
        assign lvl_act[i]  = en[i] & kind[i] & (cur[i] ^ pol[i]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [N-1:0]     edge_hit,
    input  logic [N-1:0]     lvl_act,
    output logic [N-1:0]     en_o,
    output logic [N-1:0]     mask_o,
    output logic [N-1:0]     kind_o,
    output logic [N-1:0]     any_o,
    output logic [N-1:0]     pol_o,
    output logic [N-1:0]     raw_o,
    output logic [N-1:0]     masked_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] mask;
        logic [N-1:0] kind;
        logic [N-1:0] any_edge;
        logic [N-1:0] pol;
        logic [N-1:0] raw;
    } regs_t;

    regs_t        st_d, st_q;
    logic [N-1:0] ack;
    logic [N-1:0] wbits;

    assign wbits = reg_wdata[N-1:0];

    always_comb begin
        st_d = st_q;
        ack  = '0;
        if (reg_wr) begin
            case (reg_addr)
                OFF_ENABLE: st_d.en       = wbits;
                OFF_MASK:   st_d.mask     = wbits;
                OFF_KIND:   st_d.kind     = wbits;
                OFF_ANY:    st_d.any_edge = wbits;
                OFF_POL:    st_d.pol      = wbits;
                OFF_ACK:    ack           = wbits;
                default:    ;
            endcase
        end
        for (int i = 0; i < N; i++) begin
            if (st_q.kind[i]) begin
                st_d.raw[i] = lvl_act[i];
            end else begin
                st_d.raw[i] = (st_q.raw[i] & ~ack[i]) | edge_hit[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign masked_o = st_q.raw & ~st_q.mask;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_ENABLE: reg_rdata = REG_W'(st_q.en);
            OFF_RAW:    reg_rdata = REG_W'(st_q.raw);
            OFF_MASKED: reg_rdata = REG_W'(masked_o);
            OFF_MASK:   reg_rdata = REG_W'(st_q.mask);
            OFF_KIND:   reg_rdata = REG_W'(st_q.kind);
            OFF_ANY:    reg_rdata = REG_W'(st_q.any_edge);
            OFF_POL:    reg_rdata = REG_W'(st_q.pol);
            default:    reg_rdata = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign mask_o = st_q.mask;
    assign kind_o = st_q.kind;
    assign any_o  = st_q.any_edge;
    assign pol_o  = st_q.pol;
    assign raw_o  = st_q.raw;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [N-1:0]     pins_in,
    output logic             irq_out
);
    logic [N-1:0] cur_w, prev_w;
    logic [N-1:0] edge_w, lvl_w;
    logic [N-1:0] en_w, mask_w, kind_w, any_w, pol_w;
    logic [N-1:0] raw_w, masked_w;

    gpio_irq_sync #(.N(N)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_in),
        .cur_o      (cur_w),
        .prev_o     (prev_w)
    );

    gpio_irq_sense #(.N(N)) u_sense (
        .cur      (cur_w),
        .prev     (prev_w),
        .en       (en_w),
        .kind     (kind_w),
        .any_edge (any_w),
        .pol      (pol_w),
        .edge_hit (edge_w),
        .lvl_act  (lvl_w)
    );

    gpio_irq_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .edge_hit  (edge_w),
        .lvl_act   (lvl_w),
        .en_o      (en_w),
        .mask_o    (mask_w),
        .kind_o    (kind_w),
        .any_o     (any_w),
        .pol_o     (pol_w),
        .raw_o     (raw_w),
        .masked_o  (masked_w)
    );

    assign irq_out = |masked_w;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [OFF_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq_out,
    input logic [N-1:0]     en_q,
    input logic [N-1:0]     mask_q,
    input logic [N-1:0]     raw_q
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && mask_q == '0 && raw_q == '0 && !irq_out));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0 && raw_q == '0) |=> (raw_q == '0));

    // R6
    full_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ACK && reg_wdata[N-1:0] == '1 && en_q == '0)
        |=> (raw_q == '0));

    // R8
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_out);

    // R8
    no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q == '0) |-> !irq_out);

    // R10
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_ACK) |-> (reg_rdata == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .en_q      (en_w),
    .mask_q    (mask_w),
    .raw_q     (raw_w)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pins = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_raw  = '0;
    logic [31:0] exp_mask = '0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp_data;
        logic        exp_irq;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    gpio_irq_unit u_gpio_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pins_in   (pins),
        .irq_out   (irq_out)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (reg_rdata !== it.exp_data || irq_out !== it.exp_irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, reg_rdata, irq_out, it.exp_data, it.exp_irq);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.exp_data = e;
        it.exp_irq  = |(exp_raw & ~exp_mask);
        it.tag      = tag;
        sb.push_back(it);
    endtask

    task automatic setpin(input logic [31:0] v);
        @(posedge clk); #1;
        pins = v;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(8'h20, 32'h0, "R1 enable");
        chk(8'h24, 32'h0, "R1 raw");
        chk(8'h28, 32'h0, "R1 masked");
        chk(8'h2C, 32'h0, "R1 mask");
        chk(8'h34, 32'h0, "R1 kind");
        chk(8'h38, 32'h0, "R1 any-edge");
        chk(8'h3C, 32'h0, "R1 polarity");

        // R10 readback
        wr(8'h20, 32'hFFFF_FFFF);
        chk(8'h20, 32'hFFFF_FFFF, "R10 enable readback");

        // R9 / R2 rising edge on line 0, cycle by cycle
        setpin(32'h1);
        chk(8'h24, 32'h0, "R9 edge 1");
        chk(8'h24, 32'h0, "R9 edge 2");
        exp_raw = 32'h1;
        chk(8'h24, 32'h1, "R9 edge 3");
        chk(8'h28, 32'h1, "R8 masked follows raw");
        setpin(32'h0); settle();
        chk(8'h24, 32'h1, "R2 falling ignored, status held");
        wr(8'h30, 32'h0);
        chk(8'h24, 32'h1, "R6 ack zero no effect");
        wr(8'h30, 32'h1); exp_raw = 0;
        chk(8'h24, 32'h0, "R6 ack clears edge");

        // R3 falling on line 1
        wr(8'h3C, 32'h2);
        setpin(32'h2); settle();
        chk(8'h24, 32'h0, "R3 rise ignored");
        setpin(32'h0); settle(); exp_raw = 32'h2;
        chk(8'h24, 32'h2, "R3 fall latched");
        wr(8'h30, 32'h2); exp_raw = 0;
        chk(8'h24, 32'h0, "R3 cleared");

        // R4 both edges on line 2, polarity set but ignored
        wr(8'h38, 32'h4);
        wr(8'h3C, 32'h6);
        setpin(32'h4); settle(); exp_raw = 32'h4;
        chk(8'h24, 32'h4, "R4 rise latched");
        wr(8'h30, 32'h4); exp_raw = 0;
        chk(8'h24, 32'h0, "R4 cleared");
        setpin(32'h0); settle(); exp_raw = 32'h4;
        chk(8'h24, 32'h4, "R4 fall latched");
        wr(8'h30, 32'h4); exp_raw = 0;
        chk(8'h24, 32'h0, "R4 cleared again");

        // R5 level high on line 3, level low on line 4
        wr(8'h34, 32'h18);
        chk(8'h24, 32'h0, "R5 no level yet");
        setpin(32'h8); settle(); exp_raw = 32'h8;
        chk(8'h24, 32'h8, "R5 high level asserted");
        wr(8'h30, 32'h8);
        chk(8'h24, 32'h8, "R6 ack no lasting effect on level");
        setpin(32'h0); settle(); exp_raw = 0;
        chk(8'h24, 32'h0, "R5 high level released");
        wr(8'h3C, 32'h16); exp_raw = 32'h10;
        chk(8'h24, 32'h10, "R5 low level active");
        setpin(32'h10); settle(); exp_raw = 0;
        chk(8'h24, 32'h0, "R5 low level released");

        // R8 masking on line 5
        setpin(32'h30); settle(); exp_raw = 32'h20;
        chk(8'h28, 32'h20, "R8 masked before mask");
        wr(8'h2C, 32'h20); exp_mask = 32'h20;
        chk(8'h28, 32'h0, "R8 mask hides line");
        chk(8'h24, 32'h20, "R8 raw unaffected by mask");
        wr(8'h2C, 32'h1); exp_mask = 32'h1;
        chk(8'h28, 32'h20, "R8 other mask bit");
        wr(8'h2C, 32'h0); exp_mask = 0;
        wr(8'h30, 32'h20); exp_raw = 0;
        chk(8'h24, 32'h0, "R8 cleared");

        // R7 enable gating on line 6
        wr(8'h20, 32'hFFFF_FFBF);
        chk(8'h20, 32'hFFFF_FFBF, "R10 enable readback 2");
        setpin(32'h70); settle();
        chk(8'h24, 32'h0, "R7 disabled line ignored");
        wr(8'h20, 32'hFFFF_FFFF); settle();
        chk(8'h24, 32'h0, "R7 re-enable no event");

        // R10 map
        chk(8'h30, 32'h0, "R10 ack reads zero");
        chk(8'h50, 32'h0, "R10 unmapped reads zero");
        chk(8'h34, 32'h18, "R10 kind readback");
        chk(8'h38, 32'h4, "R10 any-edge readback");
        chk(8'h3C, 32'h16, "R10 polarity readback");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule